// File: doc/BRIEF.md
# Language Card Bank Controller

This block steers the top 12 KiB of a 64 KiB address space of an 8-bit system, where RAM that can be switched in may cover the system ROM. A four-bit mode register is set by any bus access, read or write, to the sixteen switch addresses $C080 to $C08F. The loaded value is the low address nibble with bit 2 cleared. The data byte plays no part.

For every bus access in $D000 to $FFFF, the controller names a read source and a write target. Each is one of ROM, main RAM, auxiliary RAM or none. It also gives the physical RAM address to use and a write strobe. The $D000 to $DFFF window has two 4 KiB RAM banks. Bank 2 sits at its own physical addresses. Bank 1 is moved down by $1000, so it sits at physical $C000 to $CFFF. The $E000 to $FFFF region has one RAM bank and uses the same read and write mode as the window. An alternate-zero-page input sends every RAM target to auxiliary RAM. Two status bits report the selected bank and whether reads come from RAM.

The memory arrays and the other soft switches are outside this block. All results are registered.

Top module: `lc_bank_ctrl`

## Requirements
- R1: After reset the mode register holds binary 0010. This is ROM read, write inhibited, bank 2. So `stat_bank2`=1 and `stat_ramrd`=0, and `map_hit`, `mem_we`, `rd_src` and `wr_src` are all 0.
- R2: Any valid access, read or write, to $C080 to $C08F loads the mode register with the address ANDed with $0B. Address bit 2 has no effect: $C087 gives the same mode as $C083.
- R3: Mode bits [1:0] set the read and write targets. 00 reads RAM and inhibits writes. 01 reads ROM and writes RAM. 10 reads ROM and inhibits writes. 11 reads and writes RAM. Target codes are 0 none, 1 ROM, 2 main RAM, 3 auxiliary RAM.
- R4: Mode bit 3 selects the bank for $D000 to $DFFF. When bit 3 is clear (bank 2), `ram_addr` equals the bus address. When bit 3 is set (bank 1), `ram_addr` equals the bus address minus $1000.
- R5: For accesses in $E000 to $FFFF, `ram_addr` equals the bus address whatever the bank bit. The read and write targets follow the same mode as the $D000 window.
- R6: When `alt_zp` is 1, every RAM read or write target is reported as auxiliary RAM (code 3) instead of main RAM (code 2).
- R7: `stat_bank2` is 1 exactly when mode bit 3 is clear. `stat_ramrd` is 1 exactly when mode bits 0 and 1 are equal.
- R8: `mem_we` pulses only for a write access in $D000 to $FFFF whose write target is RAM. Inhibited writes are dropped. The write target is never ROM.
- R9: Accesses outside $D000 to $FFFF give `map_hit`=0 with all targets 0 and no strobe. Accesses outside $C080 to $C08F, such as $C07F and $C090, leave the mode register unchanged.
- R10: The results for an access in cycle N appear in cycle N+1. A switch access in cycle N governs the accesses from cycle N+1 onward, including an access in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus access takes place this cycle |
| bus_we | input | 1 | The access is a write |
| bus_addr | input | 16 | Bus address |
| alt_zp | input | 1 | Send RAM targets to auxiliary RAM |
| map_hit | output | 1 | The previous access fell in $D000 to $FFFF |
| rd_src | output | 2 | Read source code for the previous access |
| wr_src | output | 2 | Write target code for the previous access |
| mem_we | output | 1 | RAM write strobe for the previous access |
| ram_addr | output | 16 | Physical RAM address for the previous access |
| stat_bank2 | output | 1 | Status: $D000 bank 2 selected |
| stat_ramrd | output | 1 | Status: reads come from RAM |

## Verification
The map results for an access driven in cycle N pass through one register. The status bits follow the mode register after that same edge. So every result of an access is due exactly one cycle later.

The bench drives inputs on the falling edge. On the next falling edge it compares every output with a behavioural model. The model computes the mapping from the mode it held before the access, and only then applies any switch. This keeps a switch immediately followed by a window access cycle-exact.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ROM  = 2'd1,
    TGT_MAIN = 2'd2,
    TGT_AUX  = 2'd3
  } lc_tgt_e;

  typedef struct packed {
    lc_tgt_e rd;
    lc_tgt_e wr;
    logic    bank1;
  } lc_route_t;
endpackage

// File: rtl/lc_state_reg.sv
module lc_state_reg #(
  parameter int ADDR_W = 16,
  parameter int SPAN_LOG2 = 4,
  parameter int STATE_W = 4,
  parameter logic [ADDR_W-1:0] SW_BASE = 16'hC080,
  parameter logic [STATE_W-1:0] SW_MASK = 4'hB,
  parameter logic [STATE_W-1:0] RESET_STATE = 4'b0010
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid,
  input  logic [ADDR_W-1:0]  addr,
  output logic [STATE_W-1:0] state_q
);
  localparam int TAG_W = ADDR_W - SPAN_LOG2;
  localparam logic [TAG_W-1:0] SW_TAG = SW_BASE[ADDR_W-1:SPAN_LOG2];

  logic sw_hit;
  assign sw_hit = valid && (addr[ADDR_W-1:SPAN_LOG2] == SW_TAG);

  always_ff @(posedge clk) begin
    if (rst) state_q <= RESET_STATE;
    else if (sw_hit) state_q <= addr[STATE_W-1:0] & SW_MASK;
  end

  // R2: switch access loads masked nibble next cycle
  p_switch_load_r2: assert property (@(posedge clk) disable iff (rst)
    sw_hit |=> state_q == ($past(addr[STATE_W-1:0]) & SW_MASK));
  // R9: no switch access keeps the mode
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !sw_hit |=> $stable(state_q));
  // R2: masked bit never set
  p_bit2_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q & ~SW_MASK) == '0);
endmodule

// File: rtl/lc_mode_decode.sv
module lc_mode_decode #(
  parameter int STATE_W = 4,
  parameter int BANK_BIT = 3
) (
  input  logic [STATE_W-1:0]  state,
  input  logic                alt_zp,
  output lc_pkg::lc_route_t   route
);
  import lc_pkg::*;

  lc_tgt_e ram_tgt;
  assign ram_tgt = alt_zp ? TGT_AUX : TGT_MAIN;

  always_comb begin
    route.bank1 = state[BANK_BIT];
    unique case (state[1:0])
      2'b00: begin route.rd = ram_tgt; route.wr = TGT_NONE; end
      2'b01: begin route.rd = TGT_ROM; route.wr = ram_tgt;  end
      2'b10: begin route.rd = TGT_ROM; route.wr = TGT_NONE; end
      default: begin route.rd = ram_tgt; route.wr = ram_tgt; end
    endcase
  end
endmodule

// File: rtl/lc_map_stage.sv
module lc_map_stage #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hD000,
  parameter logic [ADDR_W-1:0] FLAT_BASE = 16'hE000,
  parameter logic [ADDR_W-1:0] BANK1_SHIFT = 16'h1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  lc_pkg::lc_route_t route,
  output logic              hit_q,
  output logic [1:0]        rd_q,
  output logic [1:0]        wr_q,
  output logic              we_q,
  output logic [ADDR_W-1:0] ram_addr_q
);
  import lc_pkg::*;

  logic hit, banked;
  logic [ADDR_W-1:0] phys;
  assign hit    = valid && (addr >= WIN_BASE);
  assign banked = (addr < FLAT_BASE) && route.bank1;
  assign phys   = banked ? (addr - BANK1_SHIFT) : addr;

  always_ff @(posedge clk) begin
    if (rst || !hit) begin
      hit_q      <= 1'b0;
      rd_q       <= TGT_NONE;
      wr_q       <= TGT_NONE;
      we_q       <= 1'b0;
      ram_addr_q <= '0;
    end else begin
      hit_q      <= 1'b1;
      rd_q       <= route.rd;
      wr_q       <= route.wr;
      we_q       <= we && (route.wr != TGT_NONE);
      ram_addr_q <= phys;
    end
  end

  // R8: ROM is never a write target
  p_no_rom_write_r8: assert property (@(posedge clk) disable iff (rst)
    wr_q != TGT_ROM);
  // R8: strobe only toward RAM
  p_we_to_ram_r8: assert property (@(posedge clk) disable iff (rst)
    we_q |-> (hit_q && wr_q[1]));
  // R9: outside window nothing is routed
  p_miss_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !hit_q |-> (!we_q && rd_q == TGT_NONE && wr_q == TGT_NONE));
  // R10: an out-of-window access yields no hit next cycle
  p_miss_next_r10: assert property (@(posedge clk) disable iff (rst)
    (valid && addr < WIN_BASE) |=> !hit_q);
endmodule

// File: rtl/lc_bank_ctrl.sv
module lc_bank_ctrl #(
  parameter int ADDR_W = 16,
  parameter int STATE_W = 4,
  parameter int BANK_BIT = 3,
  parameter logic [ADDR_W-1:0] SW_BASE = 16'hC080,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hD000,
  parameter logic [ADDR_W-1:0] FLAT_BASE = 16'hE000,
  parameter logic [ADDR_W-1:0] BANK1_SHIFT = 16'h1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              alt_zp,
  output logic              map_hit,
  output logic [1:0]        rd_src,
  output logic [1:0]        wr_src,
  output logic              mem_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              stat_bank2,
  output logic              stat_ramrd
);
  import lc_pkg::*;

  localparam int SPAN_LOG2 = 4;

  logic [STATE_W-1:0] mode_q;
  lc_route_t route;

  lc_state_reg #(
    .ADDR_W(ADDR_W), .SPAN_LOG2(SPAN_LOG2), .STATE_W(STATE_W),
    .SW_BASE(SW_BASE), .SW_MASK(4'hB), .RESET_STATE(4'b0010)
  ) u_state (
    .clk(clk), .rst(rst), .valid(bus_valid), .addr(bus_addr), .state_q(mode_q)
  );

  lc_mode_decode #(.STATE_W(STATE_W), .BANK_BIT(BANK_BIT)) u_decode (
    .state(mode_q), .alt_zp(alt_zp), .route(route)
  );

  lc_map_stage #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .FLAT_BASE(FLAT_BASE),
    .BANK1_SHIFT(BANK1_SHIFT)
  ) u_map (
    .clk(clk), .rst(rst), .valid(bus_valid), .we(bus_we), .addr(bus_addr),
    .route(route), .hit_q(map_hit), .rd_q(rd_src), .wr_q(wr_src),
    .we_q(mem_we), .ram_addr_q(ram_addr)
  );

  assign stat_bank2 = ~mode_q[BANK_BIT];
  assign stat_ramrd = ~(mode_q[0] ^ mode_q[1]);

  // R7: a window hit reads ROM exactly when RAM-read status is low
  p_ramrd_consistent_r7: assert property (@(posedge clk) disable iff (rst)
    map_hit |-> ((rd_src == TGT_ROM) == !stat_ramrd));
  // R6: auxiliary and main never mixed in one result
  p_side_consistent_r6: assert property (@(posedge clk) disable iff (rst)
    (map_hit && rd_src[1] && wr_src[1]) |-> (rd_src == wr_src));
endmodule

// File: tb/lc_bank_ctrl_tb.sv
module lc_bank_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_valid = 1'b0, bus_we = 1'b0, alt_zp = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic map_hit, mem_we, stat_bank2, stat_ramrd;
  logic [1:0] rd_src, wr_src;
  logic [15:0] ram_addr;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int mode = 2;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  lc_bank_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .alt_zp(alt_zp), .map_hit(map_hit),
    .rd_src(rd_src), .wr_src(wr_src), .mem_we(mem_we), .ram_addr(ram_addr),
    .stat_bank2(stat_bank2), .stat_ramrd(stat_ramrd)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive at falling edge, compare at next falling edge
  task automatic step(string tag, bit v, bit we, int a, bit azp);
    int e_hit, e_rd, e_wr, e_we, e_addr, ram, low;
    bus_valid = v; bus_we = we; bus_addr = a[15:0]; alt_zp = azp;
    ram = azp ? 3 : 2;
    low = mode % 4;
    e_hit = (v && a >= 'hD000) ? 1 : 0;
    e_rd = 0; e_wr = 0; e_we = 0; e_addr = 0;
    if (e_hit == 1) begin
      e_rd = (low == 1 || low == 2) ? 1 : ram;
      e_wr = (low == 1 || low == 3) ? ram : 0;
      e_we = (we && e_wr != 0) ? 1 : 0;
      e_addr = (a < 'hE000 && mode >= 8) ? a - 'h1000 : a;
    end
    if (v && a >= 'hC080 && a <= 'hC08F) mode = a % 16 & 'hB;
    @(negedge clk);
    chk(tag, "map_hit", map_hit, e_hit);
    chk(tag, "rd_src", rd_src, e_rd);
    chk(tag, "wr_src", wr_src, e_wr);
    chk(tag, "mem_we", mem_we, e_we);
    chk(tag, "ram_addr", ram_addr, e_addr);
    chk(tag, "stat_bank2", stat_bank2, (mode < 8) ? 1 : 0);
    chk(tag, "stat_ramrd", stat_ramrd, (mode % 4 == 0 || mode % 4 == 3) ? 1 : 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    while (cyc < 100000) @(negedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "stat_bank2", stat_bank2, 1);
    chk("R1", "stat_ramrd", stat_ramrd, 0);
    chk("R1", "map_hit", map_hit, 0);
    chk("R1", "mem_we", mem_we, 0);
    rst = 1'b0;
    step("R1", 1, 0, 'hD123, 0);        // ROM read after reset
    step("R8", 1, 1, 'hD123, 0);        // inhibited write
    step("R2", 1, 0, 'hC083, 0);        // mode 11 via read
    step("R3", 1, 1, 'hD456, 0);        // RAM write, next cycle: R10
    step("R6", 1, 1, 'hD456, 1);        // aux
    step("R6", 1, 0, 'hF000, 1);
    step("R2", 1, 1, 'hC08B, 0);        // bank 1 rw, via write
    step("R4", 1, 1, 'hD456, 0);
    step("R4", 1, 0, 'hDFFF, 1);
    step("R5", 1, 1, 'hE789, 0);
    step("R5", 1, 0, 'hFFFF, 0);
    step("R2", 1, 0, 'hC089, 0);        // 01 bank1
    step("R3", 1, 1, 'hD000, 0);
    step("R3", 1, 0, 'hD000, 1);
    step("R2", 1, 1, 'hC08F, 0);        // bit 2 ignored -> B
    step("R2", 1, 1, 'hD800, 0);
    step("R2", 1, 0, 'hC087, 0);        // -> 3
    step("R5", 1, 1, 'hD800, 0);
    step("R2", 1, 0, 'hC080, 0);        // 00
    step("R3", 1, 1, 'hE000, 0);
    step("R3", 1, 0, 'hE000, 1);
    step("R2", 1, 0, 'hC082, 0);        // 10
    step("R3", 1, 1, 'hD010, 1);
    step("R9", 1, 1, 'hC090, 0);        // no mode change
    step("R9", 1, 0, 'hC07F, 0);
    step("R9", 1, 1, 'h1234, 1);
    step("R9", 1, 1, 'hCFFF, 0);
    step("R9", 0, 0, 'hC081, 0);        // not valid, no load
    step("R9", 1, 1, 'hD100, 0);
    step("R10", 1, 0, 'hC08B, 0);       // switch then back-to-back window
    step("R10", 1, 1, 'hD200, 0);
    step("R10", 1, 0, 'hC081, 1);
    step("R10", 1, 1, 'hD200, 1);
    step("R7", 1, 0, 'hC08A, 0);
    step("R7", 1, 0, 'hD300, 0);
    step("R7", 0, 0, 'h0000, 0);
    finish_run();
  end
endmodule